// File: doc/BRIEF.md
# AAL1 Unstructured Cell Payload Header Generator

This block turns a stream of user bytes into 48-byte AAL1 cell payloads for unstructured traffic. Each cell carries 47 user bytes behind a one-byte segmentation header. The header holds a 3-bit cell count with an indicator bit in front of it, followed by a CRC-3 and an even-parity bit that protect it. A downstream cell builder adds the ATM header and sends the result.

When time-stamp mode is on, external logic supplies a 4-bit residual time-stamp code. The block latches that code once every eight cells and spreads its bits over the indicator bits of the odd-count cells. Even-count cells always carry an indicator of 0.

The block needs one output slot per cell for the header. It therefore holds `in_ready` low while it emits each header. Outputs are registered, one cycle after the accepting edge.

Top module: `aal1_sar_hdr_gen`

## Requirements
- R1: After reset, `out_valid`, `out_sop`, `out_eop` and `in_ready` are 0, and the first header emitted has count 0.
- R2: Every cell is 48 output bytes: a header byte with `out_sop`=1, then 47 payload bytes, the last with `out_eop`=1. `in_ready` is 0 in the cycle the header is taken, so no user byte is accepted then.
- R3: Each user byte accepted (`in_valid` and `in_ready` high at a clock edge) appears unchanged on `out_data` with `out_valid`=1 after that edge, in arrival order.
- R4: Header bits 6:4 hold the cell count. It starts at 0, rises by 1 per cell and wraps from 7 to 0.
- R5: Header bits 3:1 hold the remainder of (bits 7:4 as a polynomial, bit 7 highest) times x^3, divided by x^3+x+1.
- R6: Header bit 0 makes the number of ones in the whole header byte even.
- R7: With `ts_mode`=1, header bit 7 of the cells with counts 1, 3, 5 and 7 carries time-stamp bits 3, 2, 1 and 0 in that order. Cells with even counts carry 0.
- R8: The time-stamp code is latched from `ts_code` only when the count-0 header is emitted with `ts_valid`=1. Otherwise the previous code is reused. `ts_code` and `ts_valid` in other cells have no effect. The stored code resets to 0.
- R9: With `ts_mode`=0 at the header cycle, header bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_mode | input | 1 | Enables time-stamp bits in the header indicator bit |
| ts_code | input | 4 | Residual time-stamp code from external logic |
| ts_valid | input | 1 | `ts_code` is valid for latching |
| in_valid | input | 1 | User byte present |
| in_data | input | 8 | User byte |
| in_ready | output | 1 | Block accepts a user byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Header or payload byte |
| out_sop | output | 1 | Output byte is a cell header |
| out_eop | output | 1 | Output byte is the last of the cell |

## Verification
The bench sweeps all sixteen time-stamp codes across full eight-cell groups with time-stamp mode on. Garbage codes are presented with `ts_valid` in the non-zero-count cells, which separates latching at count 0 from latching on any valid strobe. One group runs with no valid code at count 0, which tells reuse of the old code apart from reloading or clearing it. Runs with the mode off, with `ts_valid` still asserted, separate gating of the indicator bit from gating of the latch. Some cells have idle gaps inside them, which separates per-acceptance forwarding from per-cycle forwarding. Every header is compared field by field with a count, CRC and parity model computed by long division in the bench, so a wrong wrap, a wrong polynomial term or a wrong parity each show up under their own requirement.

// File: rtl/aal1_sar_pkg.sv
package aal1_sar_pkg;

    localparam int BYTE_W = 8;
    localparam int SEQ_W  = 3;
    localparam int CRC_W  = 3;
    localparam int TS_W   = 4;

    typedef struct packed {
        logic             ind;
        logic [SEQ_W-1:0] seq;
        logic [CRC_W-1:0] crc;
        logic             par;
    } sar_hdr_t;

    typedef enum logic {
        ST_HDR = 1'b0,
        ST_PAY = 1'b1
    } sar_state_e;

    // Remainder of sn(x)*x^3 mod x^3+x+1, via per-bit residues:
    // x^6=101, x^5=111, x^4=110, x^3=011.
    function automatic logic [CRC_W-1:0] crc3_of(input logic [3:0] sn);
        logic [CRC_W-1:0] r;
        r[2] = sn[3] ^ sn[2] ^ sn[1];
        r[1] = sn[2] ^ sn[1] ^ sn[0];
        r[0] = sn[3] ^ sn[2] ^ sn[0];
        return r;
    endfunction

    function automatic sar_hdr_t build_hdr(input logic ind, input logic [SEQ_W-1:0] seq);
        sar_hdr_t h;
        h.ind = ind;
        h.seq = seq;
        h.crc = crc3_of({ind, seq});
        h.par = ^{ind, seq, h.crc};
        return h;
    endfunction

endpackage

// File: rtl/aal1_seq_tracker.sv
module aal1_seq_tracker
    import aal1_sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             ts_mode,
    input  logic [TS_W-1:0]  ts_code,
    input  logic             ts_valid,
    output logic [SEQ_W-1:0] seq,
    output logic             ind
);

    logic [SEQ_W-1:0] seq_q;
    logic [TS_W-1:0]  ts_q;
    logic [1:0]       pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
            ts_q  <= '0;
        end else if (advance) begin
            seq_q <= seq_q + 1'b1;
            if (seq_q == '0 && ts_valid) begin
                ts_q <= ts_code;
            end
        end
    end

    // Odd counts 1,3,5,7 take bits 3,2,1,0: index is the inverse of count/2.
    assign pick = ~seq_q[2:1];

    always_comb begin
        ind = 1'b0;
        if (ts_mode && seq_q[0]) begin
            ind = ts_q[pick];
        end
    end

    assign seq = seq_q;

    // R8: stored code only changes across a count-0 header
    assert_ts_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_q != '0) |=> $stable(ts_q));

endmodule

// File: rtl/aal1_hdr_encode.sv
module aal1_hdr_encode
    import aal1_sar_pkg::*;
(
    input  logic              ind,
    input  logic [SEQ_W-1:0]  seq,
    output logic [BYTE_W-1:0] hdr_byte
);

    sar_hdr_t hdr;

    always_comb begin
        hdr      = build_hdr(ind, seq);
        hdr_byte = hdr;
    end

endmodule

// File: rtl/aal1_payload_ctrl.sv
module aal1_payload_ctrl
    import aal1_sar_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 47
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic hdr_fire,
    output logic pay_fire,
    output logic pay_last
);

    localparam int CNT_W = $clog2(PAYLOAD_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_BYTES - 1);

    sar_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign in_ready = (state_q == ST_PAY);
    assign hdr_fire = (state_q == ST_HDR) && in_valid;
    assign pay_fire = (state_q == ST_PAY) && in_valid;
    assign pay_last = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
        end else if (hdr_fire) begin
            state_q <= ST_PAY;
            cnt_q   <= '0;
        end else if (pay_fire) begin
            if (pay_last) begin
                state_q <= ST_HDR;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a header slot always follows the final payload byte
    assert_hdr_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        (pay_fire && pay_last) |=> !in_ready);

endmodule

// File: rtl/aal1_sar_hdr_gen.sv
module aal1_sar_hdr_gen
    import aal1_sar_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_mode,
    input  logic [TS_W-1:0]   ts_code,
    input  logic              ts_valid,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);

    logic              hdr_fire;
    logic              pay_fire;
    logic              pay_last;
    logic [SEQ_W-1:0]  seq;
    logic              ind;
    logic [BYTE_W-1:0] hdr_byte;

    aal1_payload_ctrl #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .hdr_fire (hdr_fire),
        .pay_fire (pay_fire),
        .pay_last (pay_last)
    );

    aal1_seq_tracker u_seq (
        .clk      (clk),
        .rst      (rst),
        .advance  (hdr_fire),
        .ts_mode  (ts_mode),
        .ts_code  (ts_code),
        .ts_valid (ts_valid),
        .seq      (seq),
        .ind      (ind)
    );

    aal1_hdr_encode u_enc (
        .ind      (ind),
        .seq      (seq),
        .hdr_byte (hdr_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= hdr_fire || pay_fire;
            out_sop   <= hdr_fire;
            out_eop   <= pay_fire && pay_last;
            out_data  <= hdr_fire ? hdr_byte : in_data;
        end
    end

    // R6: every header byte has even weight
    assert_even_parity_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (^out_data == 1'b0));

    // R2: header never coincides with an accepted user byte
    assert_no_accept_in_hdr_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> !$past(in_ready));

    // R2: header and end marker are exclusive
    assert_sop_eop_excl_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));

    // R3: accepted byte forwarded unchanged
    assert_payload_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_sop && out_data == $past(in_data)));

    // R7: even-count headers carry a zero indicator
    assert_even_ind_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && !out_data[4]) |-> !out_data[7]);

    // R9: mode off gives a zero indicator
    assert_mode_off_ind_R9: assert property (@(posedge clk) disable iff (rst)
        (hdr_fire && !ts_mode) |=> !out_data[7]);

endmodule

// File: tb/aal1_sar_hdr_gen_test.sv
`timescale 1ns/1ps
module aal1_sar_hdr_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ts_mode = 1'b0;
    logic [3:0] ts_code = 4'h0;
    logic       ts_valid = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sop;
    logic       out_eop;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] d;
        bit         sop;
        bit         eop;
        string      ind_tag;
        string      cnt_tag;
    } exp_t;

    exp_t q[$];

    int         m_cnt = 0;
    logic [3:0] m_ts  = 4'h0;
    int         cell_no = 0;

    always #2.5 clk = ~clk;

    aal1_sar_hdr_gen uut (
        .clk(clk), .rst(rst), .ts_mode(ts_mode), .ts_code(ts_code), .ts_valid(ts_valid),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CRC-3 by polynomial long division, generator 1011
    function automatic int crc_div(input int nib);
        int v = nib << 3;
        for (int b = 6; b >= 3; b--) begin
            if (((v >> b) & 1) == 1) v = v ^ (11 << (b - 3));
        end
        return v & 7;
    endfunction

    function automatic logic [7:0] model_hdr(input int cnt, input bit mode, input logic [3:0] ts);
        int ind = 0;
        int nib;
        int crc;
        int ones;
        if (mode && (cnt % 2 == 1)) ind = ts[3 - cnt / 2];
        nib = ind * 8 + cnt;
        crc = crc_div(nib);
        ones = $countones(nib) + $countones(crc);
        return 8'((nib << 4) | (crc << 1) | (ones % 2));
    endfunction

    task automatic send_cell(input int seed, input bit gaps);
        exp_t e;
        logic [7:0] pay [47];
        if (m_cnt == 0 && ts_valid) m_ts = ts_code;
        e.d = model_hdr(m_cnt, ts_mode, m_ts);
        e.sop = 1; e.eop = 0;
        e.ind_tag = !ts_mode ? "R9" : (m_cnt % 2 == 1 ? "R8" : "R7");
        e.cnt_tag = (cell_no == 0) ? "R1" : "R4";
        q.push_back(e);
        for (int i = 0; i < 47; i++) begin
            pay[i] = 8'((seed * 37 + i * 13 + (i >> 3)) & 255);
            e.d = pay[i]; e.sop = 0; e.eop = (i == 46);
            e.ind_tag = ""; e.cnt_tag = "";
            q.push_back(e);
        end
        in_valid = 1'b1;
        in_data  = pay[0];
        check(in_ready == 1'b0, "R2 ready in header slot", in_ready, 0);
        @(negedge clk);
        for (int i = 0; i < 47; i++) begin
            if (gaps && (i % 9 == 4)) begin
                in_valid = 1'b0;
                in_data  = 8'hA5;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = pay[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        m_cnt = (m_cnt + 1) % 8;
        cell_no++;
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected byte", out_data, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_sop == e.sop, "R2 sop flag", out_sop, e.sop);
                check(out_eop == e.eop, "R2 eop flag", out_eop, e.eop);
                if (e.sop) begin
                    check(out_data[6:4] == e.d[6:4], {e.cnt_tag, " count field"}, out_data[6:4], e.d[6:4]);
                    check(out_data[3:1] == e.d[3:1], "R5 crc field", out_data[3:1], e.d[3:1]);
                    check(out_data[0] == e.d[0], "R6 parity bit", out_data[0], e.d[0]);
                    check(out_data[7] == e.d[7], {e.ind_tag, " indicator bit"}, out_data[7], e.d[7]);
                end else begin
                    check(out_data == e.d, "R3 payload byte", out_data, e.d);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid idle", out_valid, 0);
        check(out_sop == 1'b0 && out_eop == 1'b0, "R1 markers idle", {out_sop, out_eop}, 0);
        check(in_ready == 1'b0, "R1 in_ready idle", in_ready, 0);

        // Mode off, latch strobe present: indicator stays 0 (R9), count wraps (R4)
        ts_mode = 1'b0; ts_valid = 1'b1; ts_code = 4'hF;
        for (int c = 0; c < 9; c++) send_cell(c, c % 3 == 1);

        // Mode on: sweep every code; junk strobes in non-zero cells must be ignored (R8, R7)
        ts_mode = 1'b1;
        while (m_cnt != 0) begin
            ts_valid = 1'b1; ts_code = 4'h6;
            send_cell(100 + m_cnt, 1'b0);
        end
        for (int code = 0; code < 16; code++) begin
            for (int k = 0; k < 8; k++) begin
                ts_valid = 1'b1;
                ts_code  = (k == 0) ? 4'(code) : 4'(~code + k);
                send_cell(code * 8 + k, (k == 3));
            end
        end

        // No valid code at count 0: previous code reused (R8)
        ts_valid = 1'b0; ts_code = 4'h0;
        for (int k = 0; k < 8; k++) send_cell(300 + k, 1'b0);

        // Mode off again (R9)
        ts_mode = 1'b0; ts_valid = 1'b1; ts_code = 4'hA;
        for (int k = 0; k < 8; k++) send_cell(400 + k, 1'b1);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R2 all cell bytes emitted", q.size(), 0);
        check(out_valid == 1'b0, "R2 idle after last cell", out_valid, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule